// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns the address carried by an inbound PCI DMA transfer into a system physical address. Single-cycle requests carry a 32-bit address. Dual-cycle requests carry an address of up to 44 bits. Four programmable windows define the mapping. Each window has a base, a size mask and a translated base. A window either maps its span linearly onto memory, or looks up a 64-bit page-table entry (PTE) held in system memory for each 8 KiB page. A control register can open two further paths. One is a hole that blocks one 512 KiB span of single-cycle addresses. The other is a large identity window for dual-cycle addresses. The fourth window can also serve a dual-cycle scatter-gather range.

Software programs the windows through a simple CSR write/read port. The read data comes back in the same cycle. The requester presents an address with a valid/ready handshake and receives one response with a fault flag. The requester must accept that response with `rsp_ready`. Only one translation is in flight at a time. PTE fetches go out on a single-word read port that completes when `mem_ack` is seen.

The controller has four states. IDLE accepts a request and moves to DECIDE. DECIDE resolves the window. A direct, identity or fault outcome moves to RESP. A scatter-gather outcome moves to FETCH. FETCH holds the PTE read until `mem_ack` and then moves to RESP. RESP holds the response until `rsp_ready` and then returns to IDLE.

Top module: `dma_win_xlate`

## Requirements
- R1: After reset, `req_ready`=1, `rsp_valid`=0 and `mem_req`=0. Every window register and the control register read 0, except the base of window 3, which reads 0x2.
- R2: CSR offsets and write masks are as follows. Window w has its base at w*0x40, kept with mask 0xFFF00003; for w=3 the mask is 0x80_FFF00001 and bit 1 always reads 1. Its mask register is at 0x100+w*0x40, kept with mask 0xFFF00000. Its translated base is at 0x200+w*0x40, kept with mask 0x7_FFFFFC00. The control register is at 0x300, kept with mask 0x1CFF0FC7FF. Every other offset reads 0.
- R3: A single-cycle address hits window w when base bit 0 is set and (addr AND NOT ext) equals the base AND 0xFFF00000, where ext = mask OR 0xFFFFF. If base bit 1 is clear, the result is (tbase AND NOT ext) OR (addr AND ext). `rsp_valid` rises on the second clock edge after the request is accepted.
- R4: When several windows hit, the one with the lowest number wins.
- R5: Window 3 is used for single-cycle addresses only while its base bit 39 (dual-cycle enable) is clear.
- R6: On a scatter-gather hit (base bit 1 set), `mem_addr` = (tbase AND NOT(mask>>10)) OR ((addr AND (mask OR 0xFE000))>>10). `mem_req` is held with a stable address until `mem_ack`. A PTE with bit 0 set yields ((pte AND 0x3FFFFE)<<12) OR addr[12:0]. The response comes three edges after acceptance when `mem_ack` is returned one cycle after `mem_req`.
- R7: A fetched PTE with bit 0 clear gives a fault.
- R8: With control bit 5 set, single-cycle addresses 0x80000..0xFFFFF fault even when a window covers them.
- R9: With control bit 6 set, a dual-cycle address in [2^40, 2^41) returns its low 35 bits with no memory access.
- R10: A dual-cycle address with bit 43 set, when window 3 has base bits 0 and 39 set, reads the PTE at (tbase3 AND 0x7FFC00000) OR (addr[31:13]<<3), with the same validity check as R6.
- R11: A request that no path maps returns `rsp_fault`=1 with `rsp_addr`=0.
- R12: `req_ready` is low from acceptance until the response handshake. While `rsp_ready` is low, `rsp_valid`, `rsp_addr` and `rsp_fault` are held, and new requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR byte offset |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | CSR read data for `csr_addr` |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator idle, request accepted |
| req_addr | input | 44 | PCI address (upper 12 bits zero for single-cycle) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_fault | output | 1 | Translation failed |
| rsp_addr | output | 35 | Physical address (0 on fault) |
| mem_req | output | 1 | PTE read request |
| mem_addr | output | 35 | PTE address |
| mem_ack | input | 1 | PTE read data valid |
| mem_rdata | input | 64 | PTE value |

## Verification
The bench overlaps windows 0 and 1 and then disables window 0. A priority encoder that picks the wrong end would return the second window's translated base. The same address is sent with and without the hole bit, and with and without window 3's dual-cycle enable. A design that ignored either gate would still translate. Scatter-gather runs use pages near the top of the window and a PTE with bit 0 clear. These catch a wrong PTE index shift, a wrong page-frame mask, or an invalid entry that is accepted. A held response with a competing request checks that the design neither drops nor changes a pending answer and does not start a second translation.

// File: rtl/xl_pkg.sv
package xl_pkg;
    localparam logic [63:0] BASE_KEEP      = 64'h0000_0000_FFF0_0003;
    localparam logic [63:0] BASE_LAST_KEEP = 64'h0000_0080_FFF0_0001;
    localparam logic [63:0] BASE_SG_FORCE  = 64'h0000_0000_0000_0002;
    localparam logic [63:0] MASK_KEEP      = 64'h0000_0000_FFF0_0000;
    localparam logic [63:0] TBASE_KEEP     = 64'h0000_0007_FFFF_FC00;
    localparam logic [63:0] CTL_KEEP       = 64'h0000_1CFF_0FC7_FF;
    localparam logic [63:0] WBASE_FIELD    = 64'h0000_0000_FFF0_0000;
    localparam logic [63:0] PAGE_EXT       = 64'h0000_0000_000F_FFFF;
    localparam logic [63:0] SG_IDX         = 64'h0000_0000_000F_E000;
    localparam logic [63:0] DAC_TB         = 64'h0000_0007_FFC0_0000;
    localparam logic [63:0] DAC_IDX        = 64'h0000_0000_FFFF_E000;
    localparam logic [63:0] PTE_PFN        = 64'h0000_0000_003F_FFFE;
    localparam logic [63:0] PAGE_OFS       = 64'h0000_0000_0000_1FFF;
    localparam logic [63:0] HOLE_LO        = 64'h0000_0000_0008_0000;
    localparam logic [63:0] HOLE_HI        = 64'h0000_0000_000F_FFFF;
    localparam logic [63:0] CTL_HOLE       = 64'h0000_0000_0000_0020;
    localparam logic [63:0] CTL_IDWIN      = 64'h0000_0000_0000_0040;
    localparam int          DAC_BIT        = 39;

    typedef enum logic [1:0] {XK_FAULT, XK_DIRECT, XK_SG} kind_t;
    typedef enum logic [1:0] {ST_IDLE, ST_DECIDE, ST_FETCH, ST_RESP} st_t;
endpackage

// File: rtl/xl_regs.sv
module xl_regs
    import xl_pkg::*;
#(
    parameter int DW   = 64,
    parameter int CAW  = 12,
    parameter int NWIN = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [CAW-1:0]            addr,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             rdata,
    output logic [NWIN-1:0][DW-1:0]   base,
    output logic [NWIN-1:0][DW-1:0]   mask,
    output logic [NWIN-1:0][DW-1:0]   tbase,
    output logic [DW-1:0]             ctl
);
    localparam int STRIDE  = 64;
    localparam int OFS_BAS = 0;
    localparam int OFS_MSK = NWIN * STRIDE;
    localparam int OFS_TBA = 2 * NWIN * STRIDE;
    localparam int OFS_CTL = 3 * NWIN * STRIDE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWIN; w++) begin
                base[w]  <= (w == NWIN-1) ? DW'(BASE_SG_FORCE) : '0;
                mask[w]  <= '0;
                tbase[w] <= '0;
            end
            ctl <= '0;
        end else if (wr) begin
            for (int w = 0; w < NWIN; w++) begin
                if (addr == CAW'(OFS_BAS + w*STRIDE))
                    base[w] <= (w == NWIN-1) ? ((wdata & DW'(BASE_LAST_KEEP)) | DW'(BASE_SG_FORCE))
                                             : (wdata & DW'(BASE_KEEP));
                if (addr == CAW'(OFS_MSK + w*STRIDE))
                    mask[w] <= wdata & DW'(MASK_KEEP);
                if (addr == CAW'(OFS_TBA + w*STRIDE))
                    tbase[w] <= wdata & DW'(TBASE_KEEP);
            end
            if (addr == CAW'(OFS_CTL))
                ctl <= wdata & DW'(CTL_KEEP);
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (addr == CAW'(OFS_BAS + w*STRIDE)) rdata = base[w];
            if (addr == CAW'(OFS_MSK + w*STRIDE)) rdata = mask[w];
            if (addr == CAW'(OFS_TBA + w*STRIDE)) rdata = tbase[w];
        end
        if (addr == CAW'(OFS_CTL)) rdata = ctl;
    end
endmodule

// File: rtl/xl_decode.sv
module xl_decode
    import xl_pkg::*;
#(
    parameter int AW   = 44,
    parameter int PAW  = 35,
    parameter int DW   = 64,
    parameter int NWIN = 4
) (
    input  logic [AW-1:0]           addr,
    input  logic [NWIN-1:0][DW-1:0] base,
    input  logic [NWIN-1:0][DW-1:0] mask,
    input  logic [NWIN-1:0][DW-1:0] tbase,
    input  logic [DW-1:0]           ctl,
    output kind_t                   kind,
    output logic [PAW-1:0]          res
);
    logic [DW-1:0]   a64;
    logic            sac, hole, idw, dsg;
    logic [NWIN-1:0] hit, wsg;
    logic [PAW-1:0]  wres [NWIN];

    assign a64  = DW'(addr);
    assign sac  = (addr >> 32) == '0;
    assign hole = ((ctl & DW'(CTL_HOLE)) != '0) && (a64 >= HOLE_LO) && (a64 <= HOLE_HI);
    assign idw  = ((ctl & DW'(CTL_IDWIN)) != '0) && ((addr >> 40) == AW'(1));
    assign dsg  = addr[AW-1] && base[NWIN-1][0] && base[NWIN-1][DAC_BIT];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam bit LAST = (w == NWIN-1);
        logic [DW-1:0] ext;
        assign ext    = mask[w] | DW'(PAGE_EXT);
        assign wsg[w] = base[w][1];
        assign hit[w] = sac && !hole && base[w][0]
                     && ((a64 & ~ext) == (base[w] & DW'(WBASE_FIELD)))
                     && (!LAST || !base[w][DAC_BIT]);
        assign wres[w] = base[w][1]
            ? PAW'((tbase[w] & ~(mask[w] >> 10)) | ((a64 & (mask[w] | DW'(SG_IDX))) >> 10))
            : PAW'((tbase[w] & ~ext) | (a64 & ext));
    end

    always_comb begin
        kind = XK_FAULT;
        res  = '0;
        for (int w = NWIN-1; w >= 0; w--) begin
            if (hit[w]) begin
                kind = wsg[w] ? XK_SG : XK_DIRECT;
                res  = wres[w];
            end
        end
        if (idw) begin
            kind = XK_DIRECT;
            res  = PAW'(addr);
        end else if (dsg) begin
            kind = XK_SG;
            res  = PAW'((tbase[NWIN-1] & DW'(DAC_TB)) | ((a64 & DW'(DAC_IDX)) >> 10));
        end
    end
endmodule

// File: rtl/dma_win_xlate.sv
module dma_win_xlate
    import xl_pkg::*;
#(
    parameter int AW   = 44,
    parameter int PAW  = 35,
    parameter int DW   = 64,
    parameter int CAW  = 12,
    parameter int NWIN = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           csr_wr,
    input  logic [CAW-1:0] csr_addr,
    input  logic [DW-1:0]  csr_wdata,
    output logic [DW-1:0]  csr_rdata,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [AW-1:0]  req_addr,
    output logic           rsp_valid,
    input  logic           rsp_ready,
    output logic           rsp_fault,
    output logic [PAW-1:0] rsp_addr,
    output logic           mem_req,
    output logic [PAW-1:0] mem_addr,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata
);
    st_t                 st_q, st_d;
    logic [AW-1:0]       addr_q;
    logic [PAW-1:0]      pa_q, pte_pa, dec_res;
    logic                fault_q;
    kind_t               dec_kind;
    logic [NWIN-1:0][DW-1:0] base, mask, tbase;
    logic [DW-1:0]       ctl;

    xl_regs #(.DW(DW), .CAW(CAW), .NWIN(NWIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(csr_wr), .addr(csr_addr), .wdata(csr_wdata),
        .rdata(csr_rdata), .base(base), .mask(mask), .tbase(tbase), .ctl(ctl)
    );

    xl_decode #(.AW(AW), .PAW(PAW), .DW(DW), .NWIN(NWIN)) u_dec (
        .addr(addr_q), .base(base), .mask(mask), .tbase(tbase), .ctl(ctl),
        .kind(dec_kind), .res(dec_res)
    );

    assign pte_pa = PAW'(((mem_rdata & DW'(PTE_PFN)) << 12) | (DW'(addr_q) & DW'(PAGE_OFS)));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (req_valid) st_d = ST_DECIDE;
            ST_DECIDE: st_d = (dec_kind == XK_SG) ? ST_FETCH : ST_RESP;
            ST_FETCH:  if (mem_ack) st_d = ST_RESP;
            ST_RESP:   if (rsp_ready) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            pa_q    <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_valid) addr_q <= req_addr;
                ST_DECIDE: begin
                    fault_q <= (dec_kind == XK_FAULT);
                    pa_q    <= (dec_kind == XK_FAULT) ? '0 : dec_res;
                end
                ST_FETCH: if (mem_ack) begin
                    fault_q <= !mem_rdata[0];
                    pa_q    <= mem_rdata[0] ? pte_pa : '0;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready = (st_q == ST_IDLE);
        rsp_valid = (st_q == ST_RESP);
        mem_req   = (st_q == ST_FETCH);
        mem_addr  = pa_q;
        rsp_addr  = pa_q;
        rsp_fault = fault_q;
    end
endmodule

// File: rtl/xl_chk.sv
module xl_chk #(
    parameter int PAW = 35
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_ready,
    input logic           rsp_valid,
    input logic           rsp_ready,
    input logic           rsp_fault,
    input logic [PAW-1:0] rsp_addr,
    input logic           mem_req,
    input logic           mem_ack,
    input logic [PAW-1:0] mem_addr
);
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)); // R12
    AST_RSP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R12
    AST_RSP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> req_ready && !rsp_valid); // R12
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R6
    AST_MEM_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[2:0] == 3'b000); // R6
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !rsp_valid && !req_ready); // R6
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_addr == '0); // R11
endmodule

bind dma_win_xlate xl_chk #(.PAW(PAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/sim_dma_win_xlate.sv
module sim_dma_win_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [43:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [34:0] rsp_addr;
    logic        mem_req;
    logic [34:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;
    bit model_busy = 1'b0;
    bit done = 1'b0;
    logic [63:0] sb [4];
    logic [63:0] sm [4];
    logic [63:0] st [4];
    logic [63:0] sc;
    logic [63:0] pmem [logic [34:0]];
    logic [34:0] seen_pta = '0;

    dma_win_xlate u0 (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", r, act, exp, $time);
        end
    endtask

    // Memory responder: acknowledges one cycle after a PTE read is seen.
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= pmem.exists(mem_addr) ? pmem[mem_addr] : 64'h0;
            seen_pta  <= mem_addr;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Per-clock comparison of the handshake state against the bench model (R12)
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) chk(req_ready == !model_busy, "R12", 64'(req_ready), 64'(!model_busy));
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R12 act=%0d exp=%0d", 1, 0);
        finish_run();
    end

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        for (int w = 0; w < 4; w++) begin
            if (a == 12'(w*64))       sb[w] = (w == 3) ? ((d & 64'h80_FFF0_0001) | 64'h2) : (d & 64'hFFF0_0003);
            if (a == 12'(256 + w*64)) sm[w] = d & 64'hFFF0_0000;
            if (a == 12'(512 + w*64)) st[w] = d & 64'h7_FFFF_FC00;
        end
        if (a == 12'h300) sc = d & 64'h1CFF_0FC7FF;
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    function automatic void ref_x(input logic [43:0] a, output int kind,
                                  output logic [34:0] pa, output logic [34:0] pta);
        logic [63:0] ext, t, a64;
        a64 = {20'h0, a};
        kind = 0; pa = '0; pta = '0;
        if (a[43:32] == 12'h0) begin
            if (sc[5] && a >= 44'h8_0000 && a <= 44'hF_FFFF) return;
            for (int w = 0; w < 4; w++) begin
                if (w == 3 && sb[3][39]) continue;
                ext = sm[w] | 64'hF_FFFF;
                if (sb[w][0] && ((a64 & ~ext) == (sb[w] & 64'hFFF0_0000))) begin
                    if (sb[w][1]) begin
                        kind = 2;
                        t = (st[w] & ~(sm[w] >> 10)) | ((a64 & (sm[w] | 64'hF_E000)) >> 10);
                        pta = t[34:0];
                    end else begin
                        kind = 1;
                        t = (st[w] & ~ext) | (a64 & ext);
                        pa = t[34:0];
                    end
                    return;
                end
            end
        end else if (sc[6] && a >= 44'h100_0000_0000 && a < 44'h200_0000_0000) begin
            kind = 1;
            pa = a[34:0];
        end else if (a >= 44'h800_0000_0000 && sb[3][0] && sb[3][39]) begin
            kind = 2;
            t = (st[3] & 64'h7_FFC0_0000) | ((a64 & 64'hFFFF_E000) >> 10);
            pta = t[34:0];
        end
    endfunction

    task automatic set_pte(input logic [43:0] a, input logic [63:0] v);
        int k; logic [34:0] p, q;
        ref_x(a, k, p, q);
        pmem[q] = v;
    endtask

    task automatic xlate(input logic [43:0] a, input int hold, input string tag);
        int kind; int elat; int lat;
        logic [34:0] epa, pta;
        logic [63:0] pte;
        bit efault;
        ref_x(a, kind, epa, pta);
        efault = (kind == 0);
        elat = 2;
        if (kind == 2) begin
            elat = 3;
            pte = pmem.exists(pta) ? pmem[pta] : 64'h0;
            efault = !pte[0];
            epa = pte[0] ? 35'(((pte & 64'h3F_FFFE) << 12) | ({20'h0, a} & 64'h1FFF)) : 35'h0;
        end
        if (efault) epa = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; rsp_ready = 1'b0; model_busy = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == elat, tag, 64'(lat), 64'(elat));
        chk(rsp_fault == efault, tag, 64'(rsp_fault), 64'(efault));
        chk(rsp_addr == epa, tag, 64'(rsp_addr), 64'(epa));
        if (kind == 2) chk(seen_pta == pta, "R6", 64'(seen_pta), 64'(pta));
        for (int i = 0; i < hold; i++) begin
            req_valid = 1'b1; req_addr = 44'h5;
            @(negedge clk);
            chk(rsp_valid && rsp_addr == epa && !req_ready, "R12", 64'(rsp_addr), 64'(epa));
        end
        req_valid = 1'b0; rsp_ready = 1'b1; model_busy = 1'b0;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R12", 64'(rsp_valid), 64'(0));
    endtask

    initial begin
        logic [63:0] d;
        for (int w = 0; w < 4; w++) begin sb[w] = '0; sm[w] = '0; st[w] = '0; end
        sb[3] = 64'h2;
        sc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready && !rsp_valid && !mem_req, "R1", 64'({req_ready, rsp_valid, mem_req}), 64'h4);
        for (int w = 0; w < 4; w++) begin
            rd(12'(w*64), d);       chk(d == sb[w], "R1", d, sb[w]);
            rd(12'(256 + w*64), d); chk(d == 64'h0, "R1", d, 64'h0);
            rd(12'(512 + w*64), d); chk(d == 64'h0, "R1", d, 64'h0);
        end
        rd(12'h300, d); chk(d == 64'h0, "R1", d, 64'h0);
        rd(12'h0C0, d); chk(d == 64'h2, "R1", d, 64'h2);

        // R2: write masks
        wr(12'h000, '1); wr(12'h0C0, '1); wr(12'h100, '1); wr(12'h200, '1); wr(12'h300, '1);
        rd(12'h000, d); chk(d == 64'hFFF0_0003, "R2", d, 64'hFFF0_0003);
        rd(12'h0C0, d); chk(d == 64'h80_FFF0_0003, "R2", d, 64'h80_FFF0_0003);
        rd(12'h100, d); chk(d == 64'hFFF0_0000, "R2", d, 64'hFFF0_0000);
        rd(12'h200, d); chk(d == 64'h7_FFFF_FC00, "R2", d, 64'h7_FFFF_FC00);
        rd(12'h300, d); chk(d == 64'h1CFF_0FC7FF, "R2", d, 64'h1CFF_0FC7FF);
        rd(12'h340, d); chk(d == 64'h0, "R2", d, 64'h0);
        wr(12'h0C0, 64'h0);
        rd(12'h0C0, d); chk(d == 64'h2, "R2", d, 64'h2);
        wr(12'h000, 0); wr(12'h100, 0); wr(12'h200, 0); wr(12'h300, 0);

        // R3: direct map
        wr(12'h000, 64'h1000_0001); wr(12'h100, 64'h0030_0000); wr(12'h200, 64'h4_0000_0000);
        xlate(44'h1012_3456, 0, "R3");
        xlate(44'h103F_FFF8, 0, "R3");

        // R4: priority
        wr(12'h040, 64'h1010_0001); wr(12'h140, 64'h0); wr(12'h240, 64'h2_0000_0000);
        xlate(44'h1010_0040, 0, "R4");
        wr(12'h000, 64'h1000_0000);
        xlate(44'h1010_0040, 0, "R4");

        // R11: miss
        xlate(44'h5000_0000, 0, "R11");

        // R6 / R7: scatter-gather on window 2
        wr(12'h080, 64'h2000_0003); wr(12'h180, 64'h0010_0000); wr(12'h280, 64'h1_0000_0000);
        set_pte(44'h2012_3ABC, 64'h0000_0000_0012_3455);
        xlate(44'h2012_3ABC, 0, "R6");
        set_pte(44'h201F_E010, 64'h0000_0000_003F_FFFF);
        xlate(44'h201F_E010, 0, "R6");
        set_pte(44'h2000_4000, 64'h0000_0000_0012_3454);
        xlate(44'h2000_4000, 0, "R7");

        // R5 / R8: window 3 single-cycle and the hole
        wr(12'h0C0, 64'h1); wr(12'h1C0, 64'h0); wr(12'h2C0, 64'h3_0000_0000);
        set_pte(44'h9_0123, 64'h0000_0000_0000_0AB1);
        set_pte(44'h7_2000, 64'h0000_0000_000C_D001);
        xlate(44'h9_0123, 0, "R5");
        wr(12'h300, 64'h20);
        xlate(44'h9_0123, 0, "R8");
        xlate(44'h7_2000, 0, "R8");
        wr(12'h300, 64'h0);
        wr(12'h0C0, 64'h80_0000_0001);
        xlate(44'h7_2000, 0, "R5");

        // R9: dual-cycle identity window
        wr(12'h300, 64'h40);
        xlate(44'h123_4567_89AB, 0, "R9");
        wr(12'h300, 64'h0);
        xlate(44'h123_4567_89AB, 0, "R9");

        // R10: dual-cycle scatter-gather on window 3
        set_pte(44'h800_1234_6000, 64'h0000_0000_0005_5555);
        xlate(44'h800_1234_6000, 0, "R10");
        wr(12'h0C0, 64'h1);
        xlate(44'h800_1234_6000, 0, "R10");
        xlate(44'h1_0000_0000, 0, "R11");

        // R12: held response ignores new requests
        xlate(44'h1010_0040, 3, "R12");
        xlate(44'h2012_3ABC, 2, "R12");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule